// File: doc/BRIEF.md
# Closed-Loop Bulk Erase Sequencer

This block is the host-side controller that erases a byte-wide reprogrammable memory through a simple command bus. On a start request it enables the programming voltage and writes the erase command byte twice to arm and launch a bulk erase. It then waits a timed pulse and walks the array with verify commands, reading back each byte. The memory is erased directly, with no pass that first programs it to zero.

A byte that does not read back as all ones triggers another full-chip erase pulse. Verification then resumes at the failing address, because the bytes below it have already passed. The number of erase pulses per run is capped. On completion the sequencer writes the read command, drops the voltage enable and pulses either done or error for one cycle.

The pulse length and the pulse cap are parameters given in clock cycles and counts. The memory device itself is not part of the block.

Top module: `erase_seq`

## Requirements
- R1: While reset is held and afterwards until a start request, `vpp_en_o`, `bus_wr_o`, `bus_rd_o`, `done_o` and `error_o` are all low.
- R2: After start, the first bus writes are two write cycles on consecutive clocks, both carrying erase command 20H. No write carries any other value before that pair. Every bus write and read occurs with `vpp_en_o` high.
- R3: After each erase pair, the next bus cycle is a verify write that occurs exactly `PULSE_CLKS` clock cycles after the second 20H write. There is no bus activity in between.
- R4: A verify is a write of command A0H carrying the target address on `bus_addr_o`. The next cycle is a read strobe at the same address. Read data is sampled from `bus_rdata_i` in the cycle after the read strobe, and write and read strobes are never high together.
- R5: Verification of a run starts at address 0 and steps upward by one after each byte that reads FFH, ending at the all-ones address.
- R6: A byte reading other than FFH causes a new erase pair (20H, 20H) if the cap is not reached. The following verify resumes at that same failing address, so each failure costs exactly one extra verify read.
- R7: At most `MAX_PULSES` erase pairs are issued per run. A failing byte after the last allowed pulse ends the run with an error, including a failure at the last address.
- R8: At the end of a run, a write of read command 00H at address 0 is followed in the next cycle by a one-cycle pulse of exactly one of `done_o` (success) or `error_o` (cap exhausted), with `vpp_en_o` already low.
- R9: A start request while a run is in progress is ignored. The pulse count and the verify address are reset at every accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an erase run (accepted when idle) |
| done_o | output | 1 | One-cycle pulse: run finished with every byte erased |
| error_o | output | 1 | One-cycle pulse: pulse cap exhausted with a failing byte |
| vpp_en_o | output | 1 | Programming-voltage enable, high for the whole run |
| bus_addr_o | output | ADDR_W | Command bus address |
| bus_wdata_o | output | 8 | Command bus write data (command byte) |
| bus_wr_o | output | 1 | Command bus write strobe |
| bus_rd_o | output | 1 | Command bus read strobe |
| bus_rdata_i | input | 8 | Read data, valid the cycle after the read strobe |

## Verification
Two functions can fall into the same cycle: a byte failing verification, and the pulse cap running out. Which outcome wins decides between a re-erase and an error. The bench provokes this by giving one byte a need of one pulse more than the cap, once in the middle of the array and once at the last address. It also places a byte needing exactly the cap at the last address, which must still end in done. A start request is also injected while a run is busy, and the bench judges by exact arithmetic counts of erase pairs and verify reads that the request neither restarted the run nor reset the resume address.

// File: rtl/erase_seq_pkg.sv
`timescale 1ns/1ps
package erase_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ERASE,
        ST_WAIT,
        ST_VCMD,
        ST_VRD,
        ST_VCHK,
        ST_RDCMD,
        ST_END
    } seq_state_e;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_VERIFY  = 8'hA0;
    localparam logic [7:0] CMD_READ    = 8'h00;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] data;
        logic       use_cursor;
    } bus_op_t;

    // Bus activity implied by each state
    function automatic bus_op_t op_for(seq_state_e s);
        bus_op_t o;
        o = '{wr: 1'b0, rd: 1'b0, data: 8'h00, use_cursor: 1'b0};
        case (s)
            ST_SETUP, ST_ERASE: begin o.wr = 1'b1; o.data = CMD_ERASE; end
            ST_VCMD:  begin o.wr = 1'b1; o.data = CMD_VERIFY; o.use_cursor = 1'b1; end
            ST_VRD:   begin o.rd = 1'b1; o.use_cursor = 1'b1; end
            ST_RDCMD: begin o.wr = 1'b1; o.data = CMD_READ; end
            default:  ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pulse_timer.sv
`timescale 1ns/1ps
module pulse_timer #(
    parameter int CLKS = 20000000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic load_i,
    output logic expired_o
);
    localparam int TW = $clog2(CLKS) + 1;

    logic [TW-1:0] cnt_q;
    logic          run_q;

    // Loaded in the launching write cycle; expiry lands so that the next
    // bus cycle is exactly CLKS cycles after the load cycle.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= TW'(CLKS - 2);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/verify_cursor.sv
`timescale 1ns/1ps
module verify_cursor #(
    parameter int ADDR_W = 18
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    logic [ADDR_W-1:0] addr_q;

    // Not cleared on retry: the failing address is kept as resume point
    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) addr_q <= '0;
        else if (adv_i)     addr_q <= addr_q + 1'b1;
    end

    assign addr_o = addr_q;
    assign last_o = &addr_q;
endmodule

// File: rtl/pulse_counter.sv
`timescale 1ns/1ps
module pulse_counter #(
    parameter int MAX_PULSES = 30
) (
    input  logic                           clk_i,
    input  logic                           rst_i,
    input  logic                           clr_i,
    input  logic                           inc_i,
    output logic [$clog2(MAX_PULSES+1)-1:0] count_o,
    output logic                           spent_o
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) cnt_q <= '0;
        else if (inc_i)     cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;
    assign spent_o = (cnt_q == CW'(MAX_PULSES));
endmodule

// File: rtl/erase_seq.sv
`timescale 1ns/1ps
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int PULSE_CLKS = 20000000,
    parameter int MAX_PULSES = 30
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    output logic              done_o,
    output logic              error_o,
    output logic              vpp_en_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [7:0]        bus_wdata_o,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    input  logic [7:0]        bus_rdata_i
);
    localparam int CNT_W = $clog2(MAX_PULSES + 1);

    seq_state_e        state_q, state_d;
    logic              fail_q, fail_d;
    logic              timer_load, timer_done;
    logic              run_clr, cur_adv, cur_last;
    logic              pc_inc, pc_spent;
    logic [ADDR_W-1:0] cursor;
    logic [CNT_W-1:0]  pulse_cnt;
    logic              byte_ok;
    bus_op_t           op;

    pulse_timer #(.CLKS(PULSE_CLKS)) timer_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .load_i    (timer_load),
        .expired_o (timer_done)
    );

    verify_cursor #(.ADDR_W(ADDR_W)) cursor_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (run_clr),
        .adv_i  (cur_adv),
        .addr_o (cursor),
        .last_o (cur_last)
    );

    pulse_counter #(.MAX_PULSES(MAX_PULSES)) pcount_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (run_clr),
        .inc_i   (pc_inc),
        .count_o (pulse_cnt),
        .spent_o (pc_spent)
    );

    assign byte_ok = (bus_rdata_i == ERASED_BYTE);

    always_comb begin
        state_d    = state_q;
        fail_d     = fail_q;
        timer_load = 1'b0;
        run_clr    = 1'b0;
        cur_adv    = 1'b0;
        pc_inc     = 1'b0;
        case (state_q)
            ST_IDLE: if (start_i) begin
                run_clr = 1'b1;
                fail_d  = 1'b0;
                state_d = ST_SETUP;
            end
            ST_SETUP: state_d = ST_ERASE;
            ST_ERASE: begin
                pc_inc     = 1'b1;
                timer_load = 1'b1;
                state_d    = ST_WAIT;
            end
            ST_WAIT:  if (timer_done) state_d = ST_VCMD;
            ST_VCMD:  state_d = ST_VRD;
            ST_VRD:   state_d = ST_VCHK;
            ST_VCHK: begin
                if (byte_ok) begin
                    if (cur_last) state_d = ST_RDCMD;
                    else begin
                        cur_adv = 1'b1;
                        state_d = ST_VCMD;
                    end
                end else if (pc_spent) begin
                    fail_d  = 1'b1;
                    state_d = ST_RDCMD;
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_RDCMD: state_d = ST_END;
            ST_END:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
        end
    end

    assign op          = op_for(state_q);
    assign bus_wr_o    = op.wr;
    assign bus_rd_o    = op.rd;
    assign bus_wdata_o = op.data;
    assign bus_addr_o  = op.use_cursor ? cursor : '0;

    assign vpp_en_o = (state_q != ST_IDLE) && (state_q != ST_END);
    assign done_o   = (state_q == ST_END) && !fail_q;
    assign error_o  = (state_q == ST_END) && fail_q;
endmodule

// File: rtl/erase_seq_chk.sv
`timescale 1ns/1ps
module erase_seq_chk
    import erase_seq_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int MAX_PULSES = 30
) (
    input logic                            clk_i,
    input logic                            rst_i,
    input logic                            done_o,
    input logic                            error_o,
    input logic                            vpp_en_o,
    input logic [ADDR_W-1:0]               bus_addr_o,
    input logic [7:0]                      bus_wdata_o,
    input logic                            bus_wr_o,
    input logic                            bus_rd_o,
    input logic [$clog2(MAX_PULSES+1)-1:0] pulses_i
);
    // R1: no bus activity without the voltage enable
    a_r1_quiet_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        !vpp_en_o |-> (!bus_wr_o && !bus_rd_o));

    // R2: every bus cycle happens with the voltage enabled
    a_r2_bus_under_vpp: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_o || bus_rd_o) |-> vpp_en_o);

    // R4: verify write is followed by a read at the same address
    a_r4_read_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_wr_o && bus_wdata_o == CMD_VERIFY) |=> (bus_rd_o && $stable(bus_addr_o)));

    // R4: strobes never overlap
    a_r4_strobe_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(bus_wr_o && bus_rd_o));

    // R7: pulse count never exceeds the cap
    a_r7_pulse_cap: assert property (@(posedge clk_i) disable iff (rst_i)
        pulses_i <= ($clog2(MAX_PULSES+1))'(MAX_PULSES));

    // R8: done and error are exclusive
    a_r8_outcome_excl: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && error_o));

    // R8: outcome pulses last one cycle
    a_r8_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);
    a_r8_error_single: assert property (@(posedge clk_i) disable iff (rst_i)
        error_o |=> !error_o);

    // R8: outcome follows the read command with the voltage dropped
    a_r8_after_read_cmd: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o || error_o) |-> (!vpp_en_o && $past(bus_wr_o && bus_wdata_o == CMD_READ)));
endmodule

bind erase_seq erase_seq_chk #(
    .ADDR_W     (ADDR_W),
    .MAX_PULSES (MAX_PULSES)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .done_o      (done_o),
    .error_o     (error_o),
    .vpp_en_o    (vpp_en_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_wr_o    (bus_wr_o),
    .bus_rd_o    (bus_rd_o),
    .pulses_i    (pulse_cnt)
);

// File: tb/erase_seq_tb_top.sv
`timescale 1ns/1ps
module erase_seq_tb_top;
    localparam int AW = 4;
    localparam int PC = 8;
    localparam int MP = 30;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          done, err, vpp, wr, rd;
    logic [AW-1:0] addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata_m = 8'h00;

    always #2.5 clk = ~clk;

    erase_seq #(.ADDR_W(AW), .PULSE_CLKS(PC), .MAX_PULSES(MP)) dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start),
        .done_o(done), .error_o(err), .vpp_en_o(vpp),
        .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_wr_o(wr), .bus_rd_o(rd), .bus_rdata_i(rdata_m)
    );

    int checks = 0;
    int errs   = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    int   need [N];
    int   pulses_rx = 0;
    logic armed = 1'b0;
    logic model_clr = 1'b0;

    always @(posedge clk) begin
        if (model_clr) begin
            pulses_rx <= 0;
            armed     <= 1'b0;
        end else begin
            if (wr) begin
                if (wdata == 8'h20) begin
                    if (armed) begin
                        pulses_rx <= pulses_rx + 1;
                        armed     <= 1'b0;
                    end else armed <= 1'b1;
                end else armed <= 1'b0;
            end
            if (rd) rdata_m <= (need[addr] <= pulses_rx) ? 8'hFF : (8'h5A ^ {4'h0, addr});
        end
    end

    // ---------------- bus monitor ----------------
    logic    mon_clr = 1'b0;
    int      cyc = 0;
    int      exp_addr, last_cyc, prev_cyc, n_reads, n_done, n_err;
    int      v_r2, v_r3, v_r4, v_r5, v_r6, v_r8;
    logic [7:0]    last_data, prev_data;
    logic [AW-1:0] last_addr, pend_addr;
    logic    pend_rd, chk_rd, pre_erase;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            exp_addr = 0; last_cyc = -10; prev_cyc = -10;
            n_reads = 0; n_done = 0; n_err = 0;
            v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r8 = 0;
            last_data = 8'h11; prev_data = 8'h11; last_addr = '0; pend_addr = '0;
            pend_rd = 1'b0; chk_rd = 1'b0; pre_erase = 1'b1;
        end else begin
            if (chk_rd) begin
                if (rdata_m == 8'hFF) exp_addr++;
                chk_rd = 1'b0;
            end
            if (pend_rd) begin
                if (!(rd && addr == pend_addr)) v_r4++;
                pend_rd = 1'b0;
            end else if (rd) v_r4++;
            if (rd) begin n_reads++; chk_rd = 1'b1; end
            if ((wr || rd) && !vpp) v_r2++;
            if (wr && rd) v_r4++;
            if (wr) begin
                if (pre_erase && wdata != 8'h20) v_r2++;
                if (wdata == 8'hA0) begin
                    if (last_data == 8'h20) begin
                        if (!(prev_data == 8'h20 && prev_cyc == last_cyc - 1)) v_r2++;
                        if (cyc - last_cyc != PC) v_r3++;
                        if (int'(addr) != exp_addr) v_r6++;
                    end else if (int'(addr) != exp_addr) v_r5++;
                    pend_rd = 1'b1; pend_addr = addr;
                end else if (wdata == 8'h20) begin
                    if (last_data == 8'h20 && last_cyc == cyc - 1) pre_erase = 1'b0;
                end else if (wdata != 8'h00) v_r2++;
                prev_data = last_data; prev_cyc = last_cyc;
                last_data = wdata; last_cyc = cyc; last_addr = addr;
            end
            if (done || err) begin
                if (!(last_data == 8'h00 && last_cyc == cyc - 1 && last_addr == '0)) v_r8++;
                if (vpp) v_r8++;
                if (done && err) v_r8++;
            end
            if (done) n_done++;
            if (err)  n_err++;
        end
    end

    // ---------------- scenarios ----------------
    function automatic int need_of(int pat, int a);
        case (pat)
            0: return 1;
            1: return ((a * 7) % 5) + 1;
            2: return (a == N - 1) ? MP : 1;
            3: return (a == 5) ? MP + 1 : 1;
            4: return (a == N - 1) ? MP + 1 : 1;
            default: return N - a;
        endcase
    endfunction

    task automatic run_case(string tag, int pat, bit mid_start);
        int maxn = 0;
        int k = -1;
        int t = 0;
        bit exp_err;
        int exp_p, exp_reads;
        for (int a = 0; a < N; a++) begin
            need[a] = need_of(pat, a);
            if (need[a] > maxn) maxn = need[a];
            if (k < 0 && need[a] > MP) k = a;
        end
        exp_err   = (k >= 0);
        exp_p     = exp_err ? MP : maxn;
        exp_reads = exp_err ? (k + MP) : (N + maxn - 1);

        @(posedge clk); #1 mon_clr = 1'b1; model_clr = 1'b1;
        @(posedge clk); #1 mon_clr = 1'b0; model_clr = 1'b0; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        if (mid_start) begin
            repeat (PC + 5) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        while (n_done == 0 && n_err == 0 && t < 20000) begin
            @(posedge clk); t++;
        end
        repeat (3) @(posedge clk);
        #1;
        chk({tag, " watchdog"}, int'(t < 20000), 1);
        chk({tag, " R8 done count"}, n_done, exp_err ? 0 : 1);
        chk({tag, " R7 error count"}, n_err, exp_err ? 1 : 0);
        chk({tag, " R7 erase pairs"}, pulses_rx, exp_p);
        chk({tag, " R6 verify reads"}, n_reads, exp_reads);
        chk({tag, " R2 order/vpp"}, v_r2, 0);
        chk({tag, " R3 pulse spacing"}, v_r3, 0);
        chk({tag, " R4 verify/read"}, v_r4, 0);
        chk({tag, " R5 ascending addr"}, v_r5, 0);
        chk({tag, " R6 resume addr"}, v_r6, 0);
        chk({tag, " R8 end sequence"}, v_r8, 0);
        chk({tag, " R8 vpp low after"}, int'(vpp), 0);
        if (mid_start) chk({tag, " R9 no restart"}, n_reads, exp_reads);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        mon_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 vpp in reset", int'(vpp), 0);
        chk("R1 strobes in reset", int'(wr | rd), 0);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 vpp idle", int'(vpp), 0);
        chk("R1 outcome idle", int'(done | err), 0);
        chk("R1 strobes idle", int'(wr | rd), 0);
        mon_clr = 1'b0;

        run_case("single pulse", 0, 1'b0);
        run_case("mixed needs", 1, 1'b0);
        run_case("cap exactly at last addr", 2, 1'b0);
        run_case("cap exceeded mid", 3, 1'b0);
        run_case("R9 busy start after error", 1, 1'b1);
        run_case("cap exceeded last addr", 4, 1'b0);
        run_case("descending needs", 5, 1'b0);

        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule